// File: doc/BRIEF.md
# E1-to-T1 Continuous Channel Mapper

This block adapts a 32-timeslot system frame to a 24-channel line frame. It uses the continuous-channels scheme. System timeslot 0 is dropped. Timeslots 1 through 24 become line channels 1 through 24, in the same order. Timeslots 25 through 31 are dropped. Each line frame is 193 bits long. It starts with one framing-bit position, followed by the 24 channel bytes sent most significant bit first. The value of the framing bit comes from a dedicated input pin.

The system side writes one byte per `sys_vld` cycle, together with its timeslot index. A frame-start flag comes with the timeslot 0 byte. The line side pulls one bit per `line_en` cycle. Between the two sides sits a two-bank frame store of 24 bytes per bank. Incoming channel bytes fill one bank. When timeslot 24 of a properly started frame has been written, that bank is published. At the head of every line frame, the reader takes the most recently published bank and keeps it for the whole 193-bit frame. This means a line frame never mixes bytes from two system frames.

A 2-bit scheme field picks the mapping. Only the continuous-channels value is carried out. Any other value drives an idle, all-ones line.

Top module: `e1t1_chmap`

## Requirements
- R1: After a synchronous active-low reset, `line_vld` is 0, `line_fpos` is 0 and `line_bit` is 1.
- R2: Each cycle with `line_en` high produces exactly one line bit. `line_vld` is 1 in the cycle after a `line_en` cycle and 0 in the cycle after a cycle without `line_en`.
- R3: The line frame is 193 bits long. `line_fpos` is 1 on the first bit after reset and then on every 193rd bit, and 0 on all other bits.
- R4: In continuous mode, the framing bit equals `fbit_in` as sampled in the `line_enable` cycle that emits it. At all other bit positions, `fbit_in` is ignored.
- R5: The byte in system timeslot 0 never appears on the line.
- R6: Line channel k (1..24) carries the byte from system timeslot k, most significant bit first. Channel k occupies line bits 8k-7 to 8k, counting the framing bit as bit 0.
- R7: The bytes in system timeslots 25 to 31 never appear on the line.
- R8: A system frame is published when its timeslot 24 byte is written. A line frame carries the most recently published frame, taken whole at its framing bit. A published frame repeats until a newer one is published.
- R9: Until a first frame is published, every channel bit is 1.
- R10: `map_mode` = 2'b10 selects continuous channels. The values 2'b00, 2'b01 and 2'b11 force every line bit to 1, including the framing bit, while `line_fpos` keeps marking frame heads.
- R11: A system frame is published only if its timeslot 0 byte came with `sys_fstart`. Bytes of a frame without a start flag are not written, and the line keeps carrying the previously published frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_vld | input | 1 | A system byte is present this cycle |
| sys_fstart | input | 1 | Marks the timeslot 0 byte of a new system frame |
| sys_ts | input | 5 | Timeslot index of the byte, 0..31 |
| sys_data | input | 8 | Timeslot byte |
| map_mode | input | 2 | Mapping scheme select; 2'b10 is continuous channels |
| line_en | input | 1 | Request for the next line bit |
| fbit_in | input | 1 | Value for the framing-bit position |
| line_bit | output | 1 | Current line bit |
| line_fpos | output | 1 | The current line bit is the framing position |
| line_vld | output | 1 | A new line bit was produced in the previous cycle |

## Verification
A wrong bit or channel counter in the reader shows on the first frame as a misplaced `line_fpos` or a shifted byte. It is seen at the latest on the next framing position, 193 bits later. A wrong write address shows as a byte from a neighbouring timeslot on the affected channel, in the first line frame after publication. A bank-select or publish fault shows within one or two line frames, as a stale or mixed frame after a new frame was written. The bench therefore sweeps every bit of every line frame across several distinct system frames and all four scheme values.

// File: rtl/e1t1_pkg.sv
// Package: shared constants and the mapping-scheme encoding for the
// E1-to-T1 channel mapper. Assumes 8-bit timeslots on both sides.
package e1t1_pkg;

    localparam int BYTE_W = 8;

    // Mapping scheme select; only MAP_CONT is carried out by the mapper.
    typedef enum logic [1:0] {
        MAP_SPREAD = 2'b00,
        MAP_FILL4  = 2'b01,
        MAP_CONT   = 2'b10,
        MAP_RSVD   = 2'b11
    } map_mode_e;

endpackage

// File: rtl/e1t1_ts_writer.sv
// Module: system-side writer. Picks channel timeslots 1..NCH out of an
// NTS-slot frame, writes them into the current bank and publishes the bank
// after the last channel byte. Assumes sys_fstart comes with the slot-0
// byte; a frame without it is not written.
module e1t1_ts_writer #(
    parameter int NTS = 32,
    parameter int NCH = 24,
    localparam int TSW = $clog2(NTS),
    localparam int CHW = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sys_vld,
    input  logic                        sys_fstart,
    input  logic [TSW-1:0]              sys_ts,
    input  logic [e1t1_pkg::BYTE_W-1:0] sys_data,
    output logic                        wr_en,
    output logic                        wr_bank,
    output logic [CHW-1:0]              wr_addr,
    output logic [e1t1_pkg::BYTE_W-1:0] wr_data,
    output logic                        pub_bank,
    output logic                        pub_any
);
    localparam logic [TSW-1:0] FIRST_TS = TSW'(1);
    localparam logic [TSW-1:0] LAST_TS  = TSW'(NCH);

    logic sync_q;
    logic in_range;
    logic publish;

    // Decode whether the incoming slot is a carried channel.
    always_comb begin
        in_range = (sys_ts >= FIRST_TS) && (sys_ts <= LAST_TS);
        wr_en    = sys_vld && sync_q && in_range && !sys_fstart;
        wr_addr  = CHW'(sys_ts - FIRST_TS);
        wr_data  = sys_data;
        publish  = wr_en && (sys_ts == LAST_TS);
    end

    // Track whether the current frame began with a start flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else if (sys_vld && sys_fstart) begin
            sync_q <= 1'b1;
        end else if (publish) begin
            sync_q <= 1'b0;
        end
    end

    // Publish the filled bank and swap to the other one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bank  <= 1'b0;
            pub_bank <= 1'b0;
            pub_any  <= 1'b0;
        end else if (publish) begin
            pub_bank <= wr_bank;
            pub_any  <= 1'b1;
            wr_bank  <= ~wr_bank;
        end
    end
endmodule

// File: rtl/e1t1_frame_buf.sv
// Module: two-bank channel store, NCH bytes per bank. One write port and
// one asynchronous read port. Assumes the caller keeps the write bank
// apart from the bank being read.
module e1t1_frame_buf #(
    parameter int NCH = 24,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic                        wbank,
    input  logic [CHW-1:0]              waddr,
    input  logic [e1t1_pkg::BYTE_W-1:0] wdata,
    input  logic                        rbank,
    input  logic [CHW-1:0]              raddr,
    output logic [e1t1_pkg::BYTE_W-1:0] rdata
);
    logic [e1t1_pkg::BYTE_W-1:0] bank_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [e1t1_pkg::BYTE_W-1:0] mem [NCH];

        // Write a channel byte into this bank; cleared to idle on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NCH; i++) begin
                    mem[i] <= '1;
                end
            end else if (we && (wbank == 1'(b))) begin
                mem[waddr] <= wdata;
            end
        end

        // Read port of this bank.
        always_comb begin
            bank_rd[b] = mem[raddr];
        end
    end

    // Select the bank being read.
    always_comb begin
        rdata = rbank ? bank_rd[1] : bank_rd[0];
    end
endmodule

// File: rtl/e1t1_line_reader.sv
// Module: line-side serialiser. Emits one bit per line_en: a framing bit,
// then NCH channel bytes MSB first. Latches the published bank at every
// framing bit. Any scheme other than continuous gives all ones.
module e1t1_line_reader #(
    parameter int NCH = 24,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_en,
    input  logic                        fbit_in,
    input  logic [1:0]                  map_mode,
    input  logic                        pub_bank,
    input  logic                        pub_any,
    input  logic [e1t1_pkg::BYTE_W-1:0] rd_byte,
    output logic                        rd_bank,
    output logic [CHW-1:0]              rd_addr,
    output logic                        rd_valid,
    output logic                        at_head,
    output logic                        line_bit,
    output logic                        line_fpos,
    output logic                        line_vld
);
    localparam logic [CHW-1:0] LAST_CH = CHW'(NCH - 1);
    localparam int             BTW     = $clog2(e1t1_pkg::BYTE_W);

    logic [CHW-1:0] ch_q;
    logic [BTW-1:0] bt_q;
    logic           mode_ok;

    // Continuous mapping is the only scheme carried out.
    always_comb begin
        mode_ok = (map_mode == e1t1_pkg::MAP_CONT);
        rd_addr = ch_q;
    end

    // Advance the frame position and register the next line bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            at_head   <= 1'b1;
            ch_q      <= '0;
            bt_q      <= '1;
            rd_bank   <= 1'b0;
            rd_valid  <= 1'b0;
            line_bit  <= 1'b1;
            line_fpos <= 1'b0;
            line_vld  <= 1'b0;
        end else if (line_en) begin
            line_vld <= 1'b1;
            if (at_head) begin
                rd_bank   <= pub_bank;
                rd_valid  <= pub_any;
                line_bit  <= mode_ok ? fbit_in : 1'b1;
                line_fpos <= 1'b1;
                at_head   <= 1'b0;
                ch_q      <= '0;
                bt_q      <= '1;
            end else begin
                line_bit  <= (mode_ok && rd_valid) ? rd_byte[bt_q] : 1'b1;
                line_fpos <= 1'b0;
                bt_q      <= bt_q - 1'b1;
                if (bt_q == '0) begin
                    if (ch_q == LAST_CH) begin
                        at_head <= 1'b1;
                    end else begin
                        ch_q <= ch_q + 1'b1;
                    end
                end
            end
        end else begin
            line_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/e1t1_chmap.sv
// Module: top of the E1-to-T1 continuous channel mapper. Joins the
// system-side writer, the two-bank store and the line-side reader.
// Assumes both sides share clk and the system frame rate matches the line
// frame rate, so the writer never laps the reader's bank.
module e1t1_chmap #(
    parameter int NTS = 32,
    parameter int NCH = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sys_vld,
    input  logic                   sys_fstart,
    input  logic [$clog2(NTS)-1:0] sys_ts,
    input  logic [7:0]             sys_data,
    input  logic [1:0]             map_mode,
    input  logic                   line_en,
    input  logic                   fbit_in,
    output logic                   line_bit,
    output logic                   line_fpos,
    output logic                   line_vld
);
    localparam int CHW = $clog2(NCH);

    logic           w_wr_en;
    logic           w_wr_bank;
    logic [CHW-1:0] w_wr_addr;
    logic [7:0]     w_wr_data;
    logic           w_pub_bank;
    logic           w_pub_any;
    logic           w_rd_bank;
    logic [CHW-1:0] w_rd_addr;
    logic [7:0]     w_rd_byte;
    logic           w_rd_valid;
    logic           w_at_head;

    e1t1_ts_writer #(.NTS(NTS), .NCH(NCH)) u_writer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_vld    (sys_vld),
        .sys_fstart (sys_fstart),
        .sys_ts     (sys_ts),
        .sys_data   (sys_data),
        .wr_en      (w_wr_en),
        .wr_bank    (w_wr_bank),
        .wr_addr    (w_wr_addr),
        .wr_data    (w_wr_data),
        .pub_bank   (w_pub_bank),
        .pub_any    (w_pub_any)
    );

    e1t1_frame_buf #(.NCH(NCH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (w_wr_en),
        .wbank (w_wr_bank),
        .waddr (w_wr_addr),
        .wdata (w_wr_data),
        .rbank (w_rd_bank),
        .raddr (w_rd_addr),
        .rdata (w_rd_byte)
    );

    e1t1_line_reader #(.NCH(NCH)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_en   (line_en),
        .fbit_in   (fbit_in),
        .map_mode  (map_mode),
        .pub_bank  (w_pub_bank),
        .pub_any   (w_pub_any),
        .rd_byte   (w_rd_byte),
        .rd_bank   (w_rd_bank),
        .rd_addr   (w_rd_addr),
        .rd_valid  (w_rd_valid),
        .at_head   (w_at_head),
        .line_bit  (line_bit),
        .line_fpos (line_fpos),
        .line_vld  (line_vld)
    );
endmodule

// File: rtl/e1t1_chmap_chk.sv
// Module: property checker for the channel mapper, bound to the top.
module e1t1_chmap_chk #(
    parameter int NCH = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_en,
    input logic       line_vld,
    input logic       line_fpos,
    input logic       line_bit,
    input logic [1:0] map_mode,
    input logic       wr_en,
    input logic       wr_bank,
    input logic       rd_bank,
    input logic       rd_valid,
    input logic       at_head
);
    localparam int LBITS = 1 + 8 * NCH;

    int unsigned bit_cnt;
    logic        seen_head;

    // Count line bits since the last framing position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= 0;
            seen_head <= 1'b0;
        end else if (line_vld) begin
            bit_cnt   <= line_fpos ? 1 : bit_cnt + 1;
            seen_head <= seen_head | line_fpos;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!line_vld && !line_fpos && line_bit));

    // R2
    vld_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_en |=> line_vld);

    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> !line_vld);

    // R3
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && line_fpos && seen_head) |-> (bit_cnt == LBITS));

    // R3
    first_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && !seen_head) |-> line_fpos);

    // R10
    idle_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_en && map_mode != 2'b10) |=> line_bit);

    // R8
    no_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !at_head && rd_valid) |-> (wr_bank != rd_bank));
endmodule

bind e1t1_chmap e1t1_chmap_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_en   (line_en),
    .line_vld  (line_vld),
    .line_fpos (line_fpos),
    .line_bit  (line_bit),
    .map_mode  (map_mode),
    .wr_en     (w_wr_en),
    .wr_bank   (w_wr_bank),
    .rd_bank   (w_rd_bank),
    .rd_valid  (w_rd_valid),
    .at_head   (w_at_head)
);

// File: tb/test_e1t1_chmap.sv
module test_e1t1_chmap;
    localparam int CLK_PERIOD = 10;
    localparam int NTS        = 32;
    localparam int NCH        = 24;
    localparam int LBITS      = 1 + 8 * NCH;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sys_vld;
    logic       sys_fstart;
    logic [4:0] sys_ts;
    logic [7:0] sys_data;
    logic [1:0] map_mode;
    logic       line_en;
    logic       fbit_in;
    logic       line_bit;
    logic       line_fpos;
    logic       line_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    e1t1_chmap #(.NTS(NTS), .NCH(NCH)) i_e1t1_chmap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_vld    (sys_vld),
        .sys_fstart (sys_fstart),
        .sys_ts     (sys_ts),
        .sys_data   (sys_data),
        .map_mode   (map_mode),
        .line_en    (line_en),
        .fbit_in    (fbit_in),
        .line_bit   (line_bit),
        .line_fpos  (line_fpos),
        .line_vld   (line_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(input int f, input int ts);
        return 8'(ts * 37 + f * 91 + 5);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send one system frame of NTS bytes; with_fs flags the slot-0 byte.
    task automatic send_frame(input int f, input bit with_fs);
        for (int ts = 0; ts < NTS; ts++) begin
            @(negedge clk);
            sys_vld    = 1'b1;
            sys_ts     = 5'(ts);
            sys_data   = pat(f, ts);
            sys_fstart = with_fs && (ts == 0);
        end
        @(negedge clk);
        sys_vld    = 1'b0;
        sys_fstart = 1'b0;
    endtask

    // Pull one line frame and check every bit; src < 0 means nothing published.
    task automatic read_frame(input int src, input bit fb);
        bit mode_ok;
        mode_ok = (map_mode == 2'b10);
        for (int p = 0; p < LBITS; p++) begin
            int exp_bit;
            @(negedge clk);
            line_en = 1'b1;
            fbit_in = (p == 0) ? fb : ~fb;
            @(negedge clk);
            line_en = 1'b0;
            chk("R2 vld after en", int'(line_vld), 1);
            chk("R3 fpos", int'(line_fpos), (p == 0) ? 1 : 0);
            if (p == 0) begin
                exp_bit = mode_ok ? int'(fb) : 1;
                chk(mode_ok ? "R4 framing bit" : "R10 idle framing", int'(line_bit), exp_bit);
            end else begin
                int ch;
                int bt;
                ch = (p - 1) / 8;
                bt = 7 - ((p - 1) % 8);
                if (!mode_ok) begin
                    chk("R10 idle data", int'(line_bit), 1);
                end else if (src < 0) begin
                    chk("R9 unpublished", int'(line_bit), 1);
                end else begin
                    exp_bit = int'(pat(src, ch + 1)[bt]);
                    if (ch == 0)
                        chk("R5 R6 channel 1", int'(line_bit), exp_bit);
                    else if (ch == NCH - 1)
                        chk("R7 R6 channel 24", int'(line_bit), exp_bit);
                    else
                        chk("R6 R8 channel", int'(line_bit), exp_bit);
                end
            end
        end
        @(negedge clk);
        chk("R2 vld low without en", int'(line_vld), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        sys_vld    = 1'b0;
        sys_fstart = 1'b0;
        sys_ts     = '0;
        sys_data   = '0;
        map_mode   = 2'b10;
        line_en    = 1'b0;
        fbit_in    = 1'b0;
        repeat (3) @(negedge clk);
        // R1: idle state out of reset
        chk("R1 vld", int'(line_vld), 0);
        chk("R1 fpos", int'(line_fpos), 0);
        chk("R1 bit", int'(line_bit), 1);
        rst_n = 1'b1;

        read_frame(-1, 1'b1);          // R9 nothing published yet
        send_frame(1, 1'b1);
        read_frame(1, 1'b0);           // R5 R6 R7
        send_frame(2, 1'b0);           // R11 no start flag: not published
        read_frame(1, 1'b1);
        send_frame(3, 1'b1);
        send_frame(4, 1'b1);           // R8 newest published frame wins
        read_frame(4, 1'b0);
        read_frame(4, 1'b1);           // R8 repeats until replaced
        send_frame(5, 1'b1);
        read_frame(5, 1'b1);
        for (int m = 0; m < 4; m++) begin
            if (m != 2) begin
                map_mode = 2'(m);      // R10 idle schemes
                read_frame(5, 1'(m));
            end
        end
        map_mode = 2'b10;
        read_frame(5, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule